// File: doc/BRIEF.md
# Audio Sample Format Converter

This block sits between a 16-bit two's-complement stereo sample path and a host that wants one of four compact sample encodings. It works in two independent directions. On capture, it takes one left/right pair at a time and hands out one or two host words in the selected encoding. On playback, it takes host words and rebuilds 16-bit left/right pairs. All four edges use a valid/ready handshake.

The encoding comes from two configuration bits, a companding select and a format select, which form the code `{cfg_compand, cfg_fmt}`. A third bit chooses stereo or mono, and mono means something different in each direction. The companding follows G.711 segment arithmetic and is computed in logic.

The configuration is sampled once per pair. A pair that has already started is never encoded or decoded with two different settings.

Top module: `audio_fmt_conv`

## Requirements
- R1: Code 00 is 8-bit offset-binary. On capture the host word is `{8'h00, ~s[15], s[14:8]}`. On playback the output sample is `{~w[7], w[6:0], 8'h00}`. In every 8-bit code, host bits 15:8 are ignored on playback and are zero on capture.
- R2: Code 01 is 16-bit two's-complement. The sample passes through unchanged in both directions.
- R3: Code 10 is G.711 mu-law. The magnitude is the sample arithmetically shifted right by 2, clipped, and biased by 33. The byte is the bit inverse of {negative, segment, mantissa}. Decoding is the standard inverse, with 16-bit output.
- R4: Code 11 is G.711 A-law. The magnitude is the sample shifted right by 3, one's-complemented when negative. The byte is {positive, segment, mantissa} XOR 8'h55. Decoding is the standard inverse.
- R5: In stereo capture, an accepted pair yields two host words, left first and then right. No new pair is accepted until both words have been taken.
- R6: In mono capture, an accepted pair yields exactly one host word, built from the left channel. The right input has no effect.
- R7: In stereo playback, the first host word is the left sample and the second is the right sample. Both appear together in a single output transfer.
- R8: In mono playback, each host word is decoded once and drives both the left and right outputs.
- R9: A capture pair is encoded with the configuration present when it was accepted. A change made while its right word is still waiting does not alter that word.
- R10: If the configuration changes while a stereo playback pair holds only its left word, that word is discarded and the playback input is not ready for that cycle. The next host word is treated as a new left word under the new settings.
- R11: After reset, neither output is valid and both inputs are ready.
- R12: An output that is valid but not taken keeps its data unchanged until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stereo | input | 1 | 1 = stereo, 0 = mono |
| cfg_compand | input | 1 | Encoding code bit 1 (companded) |
| cfg_fmt | input | 1 | Encoding code bit 0 |
| cap_in_valid | input | 1 | Capture pair offered |
| cap_in_ready | output | 1 | Capture pair accepted |
| cap_in_left | input | 16 | Capture left sample |
| cap_in_right | input | 16 | Capture right sample |
| cap_out_valid | output | 1 | Host capture word valid |
| cap_out_ready | input | 1 | Host takes capture word |
| cap_out_data | output | 16 | Host capture word |
| pb_in_valid | input | 1 | Host playback word offered |
| pb_in_ready | output | 1 | Host playback word accepted |
| pb_in_data | input | 16 | Host playback word |
| pb_out_valid | output | 1 | Playback pair valid |
| pb_out_ready | input | 1 | Playback pair taken |
| pb_out_left | output | 16 | Playback left sample |
| pb_out_right | output | 16 | Playback right sample |

## Verification
A configuration change can land in the same cycle as two other events. One is a playback word arriving while a stereo left word is held. The other is a capture right word still waiting at the host edge.

The bench changes the three configuration bits at random moments while both directions carry random traffic and random backpressure. A behavioural model decides in each cycle whether the flush wins over the incoming word, and which settings each pending word belongs to. The ready, valid and data ports are compared against that model on every clock.

// File: rtl/audio_fmt_conv.sv
module audio_fmt_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_stereo,
  input  logic        cfg_compand,
  input  logic        cfg_fmt,
  input  logic        cap_in_valid,
  output logic        cap_in_ready,
  input  logic [15:0] cap_in_left,
  input  logic [15:0] cap_in_right,
  output logic        cap_out_valid,
  input  logic        cap_out_ready,
  output logic [15:0] cap_out_data,
  input  logic        pb_in_valid,
  output logic        pb_in_ready,
  input  logic [15:0] pb_in_data,
  output logic        pb_out_valid,
  input  logic        pb_out_ready,
  output logic [15:0] pb_out_left,
  output logic [15:0] pb_out_right
);

  function automatic logic [7:0] mu_enc(input logic [15:0] x);
    logic [13:0] mag;
    logic [12:0] b;
    logic [2:0]  seg;
    logic [3:0]  mant;
    mag = x[15] ? 14'(~x[15:2] + 14'd1) : x[15:2];
    b   = (mag > 14'd8158) ? 13'h1FFF : 13'(mag + 14'd33);
    seg = 3'd0;
    for (int i = 1; i < 8; i++) if (b[i+5]) seg = 3'(i);
    mant = 4'(b >> ({1'b0, seg} + 4'd1));
    return ~{x[15], seg, mant};
  endfunction

  function automatic logic [7:0] a_enc(input logic [15:0] x);
    logic [11:0] m;
    logic [2:0]  seg;
    logic [3:0]  mant;
    m   = x[15] ? ~x[14:3] : x[14:3];
    seg = 3'd0;
    for (int i = 1; i < 8; i++) if (m[i+4]) seg = 3'(i);
    mant = (seg < 3'd2) ? m[4:1] : 4'(m >> seg);
    return {~x[15], seg, mant} ^ 8'h55;
  endfunction

  function automatic logic [15:0] mu_dec(input logic [7:0] c);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~c;
    t = 16'({u[3:0], 3'b000}) + 16'd132;
    t = t << u[6:4];
    return u[7] ? 16'(16'd132 - t) : 16'(t - 16'd132);
  endfunction

  function automatic logic [15:0] a_dec(input logic [7:0] c);
    logic [7:0]  a;
    logic [15:0] t;
    a = c ^ 8'h55;
    t = {8'h00, a[3:0], 4'h0};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else                t = (t + 16'h108) << (a[6:4] - 3'd1);
    return a[7] ? t : 16'(~t + 16'd1);
  endfunction

  function automatic logic [15:0] enc(input logic [1:0] m, input logic [15:0] x);
    case (m)
      2'b00:   return {8'h00, ~x[15], x[14:8]};
      2'b01:   return x;
      2'b10:   return {8'h00, mu_enc(x)};
      default: return {8'h00, a_enc(x)};
    endcase
  endfunction

  function automatic logic [15:0] dec(input logic [1:0] m, input logic [15:0] w);
    case (m)
      2'b00:   return {~w[7], w[6:0], 8'h00};
      2'b01:   return w;
      2'b10:   return mu_dec(w[7:0]);
      default: return a_dec(w[7:0]);
    endcase
  endfunction

  wire [1:0] mode = {cfg_compand, cfg_fmt};
  wire [2:0] cfg  = {cfg_stereo, mode};

  // capture: pair encoded on acceptance, up to two words queued
  logic [1:0]  cap_cnt;
  logic [15:0] cap_w1;
  wire cap_acc  = cap_in_valid && cap_in_ready;
  wire cap_take = cap_out_valid && cap_out_ready;

  assign cap_in_ready  = (cap_cnt == 2'd0);
  assign cap_out_valid = (cap_cnt != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cnt      <= 2'd0;
      cap_out_data <= 16'h0;
      cap_w1       <= 16'h0;
    end else if (cap_acc) begin
      cap_out_data <= enc(mode, cap_in_left);
      cap_w1       <= enc(mode, cap_in_right);
      cap_cnt      <= cfg_stereo ? 2'd2 : 2'd1;
    end else if (cap_take) begin
      cap_out_data <= cap_w1;
      cap_cnt      <= cap_cnt - 2'd1;
    end
  end

  // playback: stereo left held until its right partner arrives
  logic        pb_have_left;
  logic [15:0] pb_left_hold;
  logic [2:0]  pb_cfg;
  wire pb_flush = pb_have_left && (cfg != pb_cfg);
  wire pb_acc   = pb_in_valid && pb_in_ready;
  wire [15:0] pb_dec = dec(mode, pb_in_data);

  assign pb_in_ready = !pb_out_valid && !pb_flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_have_left <= 1'b0;
      pb_left_hold <= 16'h0;
      pb_cfg       <= 3'd0;
      pb_out_valid <= 1'b0;
      pb_out_left  <= 16'h0;
      pb_out_right <= 16'h0;
    end else begin
      if (pb_out_valid && pb_out_ready) pb_out_valid <= 1'b0;
      if (pb_flush) begin
        pb_have_left <= 1'b0;
      end else if (pb_acc) begin
        if (!cfg_stereo) begin
          pb_out_left  <= pb_dec;
          pb_out_right <= pb_dec;
          pb_out_valid <= 1'b1;
        end else if (!pb_have_left) begin
          pb_left_hold <= pb_dec;
          pb_have_left <= 1'b1;
          pb_cfg       <= cfg;
        end else begin
          pb_out_left  <= pb_left_hold;
          pb_out_right <= pb_dec;
          pb_out_valid <= 1'b1;
          pb_have_left <= 1'b0;
        end
      end
    end
  end

  a_r12_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cap_out_valid && !cap_out_ready |=> cap_out_valid && $stable(cap_out_data));
  a_r12_pb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pb_out_valid && !pb_out_ready |=> pb_out_valid && $stable(pb_out_left) && $stable(pb_out_right));
  a_r5_second_word: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take && cap_cnt == 2'd2 |=> cap_out_valid && !cap_in_ready);
  a_r8_mono_dup: assert property (@(posedge clk) disable iff (!rst_n)
    pb_acc && !cfg_stereo |=> pb_out_valid && pb_out_left == pb_out_right);
  a_r10_flush_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pb_flush |=> !pb_have_left && !pb_out_valid);

endmodule

// File: tb/audio_fmt_conv_tb.sv
`timescale 1ns/1ps
module audio_fmt_conv_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_stereo, cfg_compand, cfg_fmt;
  logic cap_in_valid, cap_in_ready, cap_out_valid, cap_out_ready;
  logic [15:0] cap_in_left, cap_in_right, cap_out_data;
  logic pb_in_valid, pb_in_ready, pb_out_valid, pb_out_ready;
  logic [15:0] pb_in_data, pb_out_left, pb_out_right;

  audio_fmt_conv u_dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string ctag(input logic [1:0] m);
    case (m) 2'd0: return "R1"; 2'd1: return "R2"; 2'd2: return "R3"; default: return "R4"; endcase
  endfunction

  function automatic logic [15:0] benc(input logic [1:0] m, input logic [15:0] x);
    int v, mask, seg;
    v = {{16{x[15]}}, x};
    if (m == 2'd0) return 16'(((v >>> 8) ^ 128) & 255);
    if (m == 2'd1) return x;
    if (m == 2'd2) begin
      v = v >>> 2;
      if (v < 0) begin v = -v; mask = 8'h7F; end else mask = 8'hFF;
      if (v > 8159) v = 8159;
      v += 33;
      seg = 0;
      while (seg < 8 && v > ((64 << seg) - 1)) seg++;
      if (seg >= 8) return 16'(8'h7F ^ mask);
      return 16'(((seg << 4) | ((v >> (seg + 1)) & 15)) ^ mask);
    end
    v = v >>> 3;
    if (v >= 0) mask = 8'hD5; else begin mask = 8'h55; v = -v - 1; end
    seg = 0;
    while (seg < 8 && v > ((32 << seg) - 1)) seg++;
    if (seg >= 8) return 16'(8'h7F ^ mask);
    return 16'(((seg << 4) | ((seg < 2) ? ((v >> 1) & 15) : ((v >> seg) & 15))) ^ mask);
  endfunction

  function automatic logic [15:0] bdec(input logic [1:0] m, input logic [15:0] w);
    int u, t, seg;
    if (m == 2'd0) return 16'(((w & 255) ^ 128) << 8);
    if (m == 2'd1) return w;
    if (m == 2'd2) begin
      u = ~w & 255;
      t = ((u & 15) << 3) + 132;
      t = t << ((u & 112) >> 4);
      return 16'((u & 128) ? (132 - t) : (t - 132));
    end
    u = (w & 255) ^ 85;
    t = (u & 15) << 4;
    seg = (u & 112) >> 4;
    if (seg == 0) t += 8;
    else t = (t + 264) << (seg - 1);
    return 16'((u & 128) ? t : -t);
  endfunction

  typedef struct { logic [15:0] w; logic [1:0] m; bit st; } ent_t;
  ent_t capq[$];
  bit m_have, m_valid;
  logic [2:0] m_cfg, m_pcfg;
  logic [15:0] m_left, m_L, m_R;

  wire [2:0] cur = {cfg_stereo, cfg_compand, cfg_fmt};

  always @(posedge clk) begin
    if (!rst_n) begin
      capq.delete(); m_have = 0; m_valid = 0;
    end else begin
      bit fl, rdy;
      logic [15:0] d;
      if (cap_in_valid && capq.size() == 0) begin
        capq.push_back('{benc(cur[1:0], cap_in_left), cur[1:0], cur[2]});
        if (cur[2]) capq.push_back('{benc(cur[1:0], cap_in_right), cur[1:0], 1'b1});
      end else if (capq.size() != 0 && cap_out_ready) begin
        void'(capq.pop_front());
      end
      fl  = m_have && (cur != m_cfg);
      rdy = !m_valid && !fl;
      if (m_valid && pb_out_ready) m_valid = 0;
      if (fl) m_have = 0;
      else if (pb_in_valid && rdy) begin
        d = bdec(cur[1:0], pb_in_data);
        if (!cur[2]) begin m_L = d; m_R = d; m_valid = 1; m_pcfg = cur; end
        else if (!m_have) begin m_left = d; m_have = 1; m_cfg = cur; end
        else begin m_L = m_left; m_R = d; m_valid = 1; m_have = 0; m_pcfg = cur; end
      end
    end
  end

  bit c_stall = 0, p_stall = 0;
  logic [15:0] c_prev, pl_prev, pr_prev;

  always @(negedge clk) begin
    if (rst_n) begin
      bit fl;
      string t;
      fl = m_have && (cur != m_cfg);
      chk(cap_in_ready == (capq.size() == 0), "R5 cap_in_ready", 32'(cap_in_ready), 32'(capq.size() == 0));
      chk(cap_out_valid == (capq.size() != 0), "R6 cap_out_valid", 32'(cap_out_valid), 32'(capq.size() != 0));
      if (capq.size() != 0) begin
        t = {ctag(capq[0].m), capq[0].st ? "/R5" : "/R6", (capq[0].m != cur[1:0]) ? "/R9" : ""};
        chk(cap_out_data == capq[0].w, t, 32'(cap_out_data), 32'(capq[0].w));
      end
      chk(pb_in_ready == (!m_valid && !fl), "R10 pb_in_ready", 32'(pb_in_ready), 32'(!m_valid && !fl));
      chk(pb_out_valid == m_valid, "R7 pb_out_valid", 32'(pb_out_valid), 32'(m_valid));
      if (m_valid) begin
        t = {ctag(m_pcfg[1:0]), m_pcfg[2] ? "/R7" : "/R8"};
        chk(pb_out_left == m_L, t, 32'(pb_out_left), 32'(m_L));
        chk(pb_out_right == m_R, t, 32'(pb_out_right), 32'(m_R));
      end
      if (c_stall) chk(cap_out_data == c_prev, "R12 cap hold", 32'(cap_out_data), 32'(c_prev));
      if (p_stall) chk({pb_out_left, pb_out_right} == {pl_prev, pr_prev}, "R12 pb hold",
                       {pb_out_left, pb_out_right}, {pl_prev, pr_prev});
      c_stall = cap_out_valid && !cap_out_ready; c_prev = cap_out_data;
      p_stall = pb_out_valid && !pb_out_ready; pl_prev = pb_out_left; pr_prev = pb_out_right;
    end
  end

  function automatic logic [15:0] pick();
    case ($urandom % 8)
      0: return 16'h8000; 1: return 16'h7FFF; 2: return 16'h0000; 3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic drive(input bit chg);
    @(posedge clk); #1;
    cap_in_valid  = ($urandom % 2) == 0;
    cap_in_left   = pick();
    cap_in_right  = pick();
    cap_out_ready = ($urandom % 4) != 0;
    pb_in_valid   = ($urandom % 3) != 0;
    pb_in_data    = 16'($urandom);
    pb_out_ready  = ($urandom % 4) != 0;
    if (chg && ($urandom % 5) == 0) {cfg_stereo, cfg_compand, cfg_fmt} = 3'($urandom);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 0; {cfg_stereo, cfg_compand, cfg_fmt} = 3'd0;
    cap_in_valid = 0; cap_in_left = 0; cap_in_right = 0; cap_out_ready = 0;
    pb_in_valid = 0; pb_in_data = 0; pb_out_ready = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!cap_out_valid && !pb_out_valid, "R11 reset valids", {cap_out_valid, pb_out_valid}, 0);
    chk(cap_in_ready && pb_in_ready, "R11 reset readies", {cap_in_ready, pb_in_ready}, 2'b11);
    for (int md = 0; md < 8; md++) begin
      @(posedge clk); #1 {cfg_stereo, cfg_compand, cfg_fmt} = 3'(md);
      repeat (400) drive(0);
    end
    repeat (4000) drive(1);
    @(posedge clk); #1;
    cap_in_valid = 0; pb_in_valid = 0; cap_out_ready = 1; pb_out_ready = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule